// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the address stream for a single DMA channel. Software hands it a four-word transfer descriptor in one load cycle: a start address word, an X word (count and step for the inner dimension), a Y word (count and step for the outer dimension) and a control word. From then on the block presents one word address per beat at the selected operand size of one, two or four 32-bit words. It walks either a single linear run or a grid of rows. At the end of each row it jumps by the Y step, so the rows of a sub-matrix can be gathered from a larger array.

Counts and steps are always in 32-bit word units, whatever the operand size. A row holds X count words. Each beat consumes as many words of that count as the operand carries. The last beat of the last row closes the block: the block pulses a completion strobe and, if enabled, an interrupt strobe. The channel either issues beats back to back, limited only by the consumer's ready signal, or paces them so that each beat needs a request from the peripheral. A descriptor that is malformed raises an error flag and leaves the channel idle. The memory, the bus protocol and descriptor chaining lie outside this block.

Top module: `dma2d_agen`

## Requirements
- R1: After reset, addr_valid, busy, done, irq and cfg_err are all 0.
- R2: A load whose control bits 31:29 are non-zero and whose descriptor is valid sets busy in the next cycle and presents the start address word as the first address. A load with bits 31:29 equal to 000 stops the channel: busy and addr_valid go to 0 and no done pulse follows.
- R3: The X word holds the row count in bits 31:16 and a signed step in bits 15:0. Inside a row, each accepted beat (addr_valid and addr_ready high at a clock edge) moves the address by the sign-extended step.
- R4: Control bits 26:25 select the operand size, and beat_words reports it: 01 gives 1 word, 10 gives 2 words and 11 gives 4 words. A row takes ceil(X count / operand words) beats.
- R5: With control bit 27 set, the Y word gives the number of rows in bits 31:16 and a signed row-end step in bits 15:0. The last beat of each row moves the address by the Y step instead of the X step, and the X count restarts.
- R6: With control bit 27 clear, the block runs exactly one row and the contents of the Y word have no effect.
- R7: With control bit 23 clear, addr_valid stays high on every cycle while busy. While addr_ready is low, addr_valid and addr stay unchanged.
- R8: With control bit 23 set, the channel holds one pending-request flag. A cycle with req high sets it, an accepted beat clears it, and a request in the same cycle as an accepted beat keeps it set. A load clears it. addr_valid is busy AND the flag.
- R9: The cycle after the final beat is accepted, done is high for exactly one cycle and busy and addr_valid are 0.
- R10: irq pulses together with done only when control bit 24 was set in the descriptor. Otherwise it stays 0.
- R11: A load with non-zero bits 31:29 sets cfg_err and leaves the channel idle in either of these cases: the operand size field is 00, or the X count is zero (or the Y count is zero with bit 27 set). The next load recomputes cfg_err, so a valid load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Descriptor load strobe |
| tcb_index | input | 32 | Start address word |
| tcb_xword | input | 32 | X count (31:16) and X step (15:0) |
| tcb_yword | input | 32 | Y count (31:16) and Y step (15:0) |
| tcb_ctrl | input | 32 | Control word: type 31:29, 2D 27, size 26:25, irq 24, paced 23 |
| req | input | 1 | Peripheral request in paced mode |
| addr_ready | input | 1 | Consumer accepts the presented address |
| addr_valid | output | 1 | An address beat is presented |
| addr | output | ADDR_W | Word address of the current beat |
| beat_words | output | 3 | Words carried by each beat (1, 2 or 4) |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle block completion pulse |
| irq | output | 1 | One-cycle interrupt pulse at completion |
| cfg_err | output | 1 | Last load carried a malformed descriptor |

## Verification
Two events can fall in the same clock edge, and both must be handled together. In paced mode, a new request can arrive in the very cycle a pending beat is accepted. On the final beat of a grid, the row end and the block end coincide. The bench provokes both with dense random ready and request patterns and with grids whose rows are one beat long. It judges them by comparing addr_valid, the address, done and busy at the following edge against a walk model that counts columns and rows from the descriptor fields.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int TCB_W    = 32;
  localparam int CNT_W    = 16;
  localparam int MOD_W    = 16;
  localparam int WSZ_W    = 3;
  localparam int TYPE_W   = 3;
  // control word field positions
  localparam int TYPE_LSB = 29;
  localparam int DIM2_BIT = 27;
  localparam int LEN_LSB  = 25;
  localparam int IRQ_BIT  = 24;
  localparam int PACE_BIT = 23;
  // count/step word layout
  localparam int CNT_LSB  = 16;

  typedef enum logic [1:0] {
    OPLEN_RSVD = 2'b00,
    OPLEN_ONE  = 2'b01,
    OPLEN_TWO  = 2'b10,
    OPLEN_FOUR = 2'b11
  } oplen_e;

  typedef struct packed {
    logic [CNT_W-1:0] xcnt;
    logic [MOD_W-1:0] xmod;
    logic [CNT_W-1:0] ycnt;
    logic [MOD_W-1:0] ymod;
    logic             two_d;
    logic             paced;
    logic             irq_en;
    logic [WSZ_W-1:0] words;
  } walk_cfg_t;

  function automatic logic [WSZ_W-1:0] oplen_words(input oplen_e l);
    case (l)
      OPLEN_ONE:  return WSZ_W'(1);
      OPLEN_TWO:  return WSZ_W'(2);
      OPLEN_FOUR: return WSZ_W'(4);
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/dma2d_tcb_decode.sv
module dma2d_tcb_decode
  import dma2d_pkg::*;
(
  input  logic [TCB_W-1:0] xword,
  input  logic [TCB_W-1:0] yword,
  input  logic [TCB_W-1:0] ctrl,
  output walk_cfg_t        cfg,
  output logic             typed,
  output logic             bad
);
  oplen_e len;
  logic   two_d;
  logic   unused_ctrl_bits;

  always_comb begin
    len         = oplen_e'(ctrl[LEN_LSB +: 2]);
    two_d       = ctrl[DIM2_BIT];
    typed       = |ctrl[TYPE_LSB +: TYPE_W];
    cfg.xcnt    = xword[CNT_LSB +: CNT_W];
    cfg.xmod    = xword[0 +: MOD_W];
    // a one-dimensional run is a single row; the Y word is not consulted
    cfg.ycnt    = two_d ? yword[CNT_LSB +: CNT_W] : CNT_W'(1);
    cfg.ymod    = two_d ? yword[0 +: MOD_W] : '0;
    cfg.two_d   = two_d;
    cfg.paced   = ctrl[PACE_BIT];
    cfg.irq_en  = ctrl[IRQ_BIT];
    cfg.words   = oplen_words(len);
    bad         = typed && ((len == OPLEN_RSVD) || (cfg.xcnt == '0) || (cfg.ycnt == '0));
  end

  assign unused_ctrl_bits = ^{ctrl[TYPE_LSB-1], ctrl[PACE_BIT-1:0]};
endmodule

// File: rtl/dma2d_issue_gate.sv
module dma2d_issue_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic busy,
  input  logic paced,
  input  logic req,
  input  logic addr_ready,
  output logic addr_valid,
  output logic fire
);
  logic pend_q, pend_d;

  always_comb begin
    addr_valid = busy && (!paced || pend_q);
    fire       = addr_valid && addr_ready;
    if (load) pend_d = 1'b0;
    else      pend_d = req || (pend_q && !fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R8: in paced mode a beat only appears after a request was seen
  a_r8_paced_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (paced && $rose(addr_valid)) |-> $past(req));
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              fire,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_xcnt,
  input  logic [CNT_W-1:0]  start_ycnt,
  input  logic [CNT_W-1:0]  run_xcnt,
  input  logic [MOD_W-1:0]  run_xmod,
  input  logic [MOD_W-1:0]  run_ymod,
  input  logic [WSZ_W-1:0]  run_words,
  input  logic              run_irq_en,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  localparam int EXT_W = ADDR_W - MOD_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  xrem_q, xrem_d;
  logic [CNT_W-1:0]  yrem_q, yrem_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              irq_q,  irq_d;
  logic [CNT_W-1:0]  wsz;
  logic [ADDR_W-1:0] xstep, ystep;
  logic              row_end, blk_end;

  always_comb begin
    wsz     = {{(CNT_W-WSZ_W){1'b0}}, run_words};
    xstep   = {{EXT_W{run_xmod[MOD_W-1]}}, run_xmod};
    ystep   = {{EXT_W{run_ymod[MOD_W-1]}}, run_ymod};
    row_end = (xrem_q <= wsz);
    blk_end = row_end && (yrem_q == CNT_W'(1));

    addr_d = addr_q;
    xrem_d = xrem_q;
    yrem_d = yrem_q;
    busy_d = busy_q;
    done_d = 1'b0;
    irq_d  = 1'b0;
    if (stop) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      addr_d = start_addr;
      xrem_d = start_xcnt;
      yrem_d = start_ycnt;
    end else if (fire) begin
      if (blk_end) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        irq_d  = run_irq_en;
      end else if (row_end) begin
        addr_d = addr_q + ystep;
        xrem_d = run_xcnt;
        yrem_d = yrem_q - CNT_W'(1);
      end else begin
        addr_d = addr_q + xstep;
        xrem_d = xrem_q - wsz;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      xrem_q <= '0;
      yrem_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      xrem_q <= xrem_d;
      yrem_q <= yrem_d;
      busy_q <= busy_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign addr = addr_q;
  assign busy = busy_q;
  assign done = done_q;
  assign irq  = irq_q;

  // R5: an active walk always has words left in the row and rows left
  a_r5_counts_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((xrem_q != '0) && (yrem_q != '0)));
  // R9: completion closes a walk that was running
  a_r9_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R10: the interrupt strobe never appears outside completion
  a_r10_irq_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);
  // R2: an idle channel keeps its address until the next start
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(addr_q));
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TCB_W-1:0]  tcb_index,
  input  logic [TCB_W-1:0]  tcb_xword,
  input  logic [TCB_W-1:0]  tcb_yword,
  input  logic [TCB_W-1:0]  tcb_ctrl,
  input  logic              req,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic [WSZ_W-1:0]  beat_words,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              cfg_err
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_core_n;
  walk_cfg_t         dec_cfg, cfg_q, cfg_d;
  logic              typed, bad, start, stop, fire;
  logic              err_q, err_d;
  logic              unused_cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_N-1];

  dma2d_tcb_decode u_decode (
    .xword (tcb_xword),
    .yword (tcb_yword),
    .ctrl  (tcb_ctrl),
    .cfg   (dec_cfg),
    .typed (typed),
    .bad   (bad)
  );

  always_comb begin
    start = load && typed && !bad;
    stop  = load && !start;
    cfg_d = start ? dec_cfg : cfg_q;
    err_d = load ? bad : err_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  dma2d_issue_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (load),
    .busy       (busy),
    .paced      (cfg_q.paced),
    .req        (req),
    .addr_ready (addr_ready),
    .addr_valid (addr_valid),
    .fire       (fire)
  );

  dma2d_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .stop       (stop),
    .fire       (fire),
    .start_addr (tcb_index[ADDR_W-1:0]),
    .start_xcnt (dec_cfg.xcnt),
    .start_ycnt (dec_cfg.ycnt),
    .run_xcnt   (cfg_q.xcnt),
    .run_xmod   (cfg_q.xmod),
    .run_ymod   (cfg_q.ymod),
    .run_words  (cfg_q.words),
    .run_irq_en (cfg_q.irq_en),
    .addr       (addr),
    .busy       (busy),
    .done       (done),
    .irq        (irq)
  );

  assign beat_words = cfg_q.words;
  assign cfg_err    = err_q;
  assign unused_cfg = ^{cfg_q.ycnt, cfg_q.two_d};

  // R7: a stalled beat keeps its address and stays offered
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid && !addr_ready && !load) |=> (addr_valid && $stable(addr)));
  // R11: an erroneous load never leaves the channel running
  a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_err |-> !busy);
  // R4: an active channel always carries exactly one legal operand size
  a_r4_one_size: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |-> ($countones(beat_words) == 1));
endmodule

// File: tb/tb_dma2d_agen.sv
`timescale 1ns/1ps
module tb_dma2d_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] tcb_index = '0, tcb_xword = '0, tcb_yword = '0, tcb_ctrl = '0;
  logic        req = 1'b0, addr_ready = 1'b0;
  logic        addr_valid, busy, done, irq, cfg_err;
  logic [31:0] addr;
  logic [2:0]  beat_words;
  int          n_checks = 0, n_err = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  dma2d_agen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .tcb_index(tcb_index),
    .tcb_xword(tcb_xword), .tcb_yword(tcb_yword), .tcb_ctrl(tcb_ctrl),
    .req(req), .addr_ready(addr_ready), .addr_valid(addr_valid), .addr(addr),
    .beat_words(beat_words), .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int op_words(input logic [1:0] l);
    case (l)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mkctl(input logic [2:0] ty, input logic d2,
                                        input logic [1:0] ln, input logic ie, input logic pc);
    return {ty, 1'b0, d2, ln, ie, pc, 23'h0};
  endfunction

  task automatic do_load(input logic [31:0] idx, xw, yw, ctl);
    load = 1'b1; tcb_index = idx; tcb_xword = xw; tcb_yword = yw; tcb_ctrl = ctl;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_xfer(input logic [31:0] idx, xw, yw, ctl,
                          input int rdy_pct, input int req_pct, input int quiet);
    int words, bpr, rows, col, row, iter, beats;
    logic [31:0] maddr, xs, ys;
    bit paced, pend, busy_m, fire, rdy, rq, expv;
    words = op_words(ctl[26:25]);
    bpr   = (int'(xw[31:16]) + words - 1) / words;
    rows  = ctl[27] ? int'(yw[31:16]) : 1;
    xs    = {{16{xw[15]}}, xw[15:0]};
    ys    = {{16{yw[15]}}, yw[15:0]};
    paced = ctl[23];
    do_load(idx, xw, yw, ctl);
    chk("R2 busy after load", {31'b0, busy}, 32'd1);
    chk("R2 first address", addr, idx);
    chk("R11 error clear on good load", {31'b0, cfg_err}, 32'd0);
    maddr = idx; col = 0; row = 0; pend = 0; busy_m = 1; iter = 0; beats = 0;
    while (busy_m && iter < 20000) begin
      expv = !paced || pend;
      chk(paced ? "R8 valid" : "R7 valid", {31'b0, addr_valid}, {31'b0, expv});
      if (expv) begin
        chk(ctl[27] ? "R5 address" : "R3 address", addr, maddr);
        chk("R4 beat words", {29'b0, beat_words}, 32'(words));
      end
      rdy = ($urandom % 100) < rdy_pct;
      rq  = paced && (iter >= quiet) && (($urandom % 100) < req_pct);
      addr_ready = rdy; req = rq;
      fire = expv && rdy;
      if (fire) begin
        beats++;
        if (col == bpr - 1) begin
          if (row == rows - 1) busy_m = 0;
          else begin maddr += ys; col = 0; row++; end
        end else begin
          maddr += xs; col++;
        end
      end
      pend = rq || (pend && !fire);
      iter++;
      @(negedge clk);
    end
    addr_ready = 1'b0; req = 1'b0;
    chk(ctl[27] ? "R5 beat total" : "R6 beat total", 32'(beats), 32'(bpr * rows));
    chk("R9 done pulse", {31'b0, done}, 32'd1);
    chk("R9 busy clear", {31'b0, busy}, 32'd0);
    chk("R9 valid low", {31'b0, addr_valid}, 32'd0);
    chk("R10 irq at done", {31'b0, irq}, {31'b0, ctl[24]});
    @(negedge clk);
    chk("R9 done single cycle", {31'b0, done}, 32'd0);
    chk("R10 irq single cycle", {31'b0, irq}, 32'd0);
  endtask

  task automatic load_bad(input logic [31:0] xw, yw, ctl, input string tag);
    do_load(32'h200, xw, yw, ctl);
    chk({"R11 flag ", tag}, {31'b0, cfg_err}, 32'd1);
    chk({"R11 idle ", tag}, {31'b0, busy}, 32'd0);
    addr_ready = 1'b1;
    @(negedge clk);
    chk({"R11 no beat ", tag}, {31'b0, addr_valid}, 32'd0);
    addr_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'b0, addr_valid}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 cfg_err", {31'b0, cfg_err}, 32'd0);

    // R3/R4 linear quad-word run, irq on
    run_xfer(32'h100, {16'd16, 16'd4}, 32'h0, mkctl(3'd2, 1'b0, 2'b11, 1'b1, 1'b0), 100, 0, 0);
    // R3 negative step, single words, stalls
    run_xfer(32'h10, {16'd4, 16'hFFFF}, 32'h0, mkctl(3'd4, 1'b0, 2'b01, 1'b0, 1'b0), 50, 0, 0);
    // R4 count not a multiple of operand size: 5 words, quad -> 2 beats
    run_xfer(32'h300, {16'd5, 16'd4}, 32'h0, mkctl(3'd1, 1'b0, 2'b11, 1'b1, 1'b0), 100, 0, 0);
    // R5 8x8 grid in quad words
    run_xfer(32'h1000, {16'd8, 16'd4}, {16'd8, 16'd4}, mkctl(3'd2, 1'b1, 2'b11, 1'b1, 1'b0), 80, 0, 0);
    // R5 sub-matrix with gaps between rows
    run_xfer(32'h0, {16'd3, 16'd1}, {16'd2, 16'd5}, mkctl(3'd2, 1'b1, 2'b01, 1'b0, 1'b0), 70, 0, 0);
    // R5 one-beat rows: row end and block end share the last beat
    run_xfer(32'h40, {16'd2, 16'd2}, {16'd3, 16'hFFF0}, mkctl(3'd2, 1'b1, 2'b10, 1'b1, 1'b0), 100, 0, 0);
    // R6 Y word full of junk while 2D is off
    run_xfer(32'h500, {16'd6, 16'd2}, 32'hFFFF_FFFF, mkctl(3'd5, 1'b0, 2'b10, 1'b0, 1'b0), 60, 0, 0);
    // R8 paced: no request for the first cycles, then sparse requests
    run_xfer(32'h800, {16'd4, 16'd2}, {16'd3, 16'd6}, mkctl(3'd2, 1'b1, 2'b10, 1'b1, 1'b1), 70, 40, 6);
    // R8 paced with dense requests and full ready (request meets accept)
    run_xfer(32'h900, {16'd8, 16'd1}, 32'h0, mkctl(3'd2, 1'b0, 2'b01, 1'b0, 1'b1), 100, 100, 0);

    // R11 malformed descriptors
    load_bad({16'd0, 16'd1}, 32'h0, mkctl(3'd2, 1'b0, 2'b01, 1'b0, 1'b0), "xcount zero");
    load_bad({16'd4, 16'd1}, 32'h0, mkctl(3'd2, 1'b0, 2'b00, 1'b0, 1'b0), "reserved size");
    load_bad({16'd4, 16'd1}, {16'd0, 16'd1}, mkctl(3'd2, 1'b1, 2'b01, 1'b0, 1'b0), "ycount zero");
    run_xfer(32'h20, {16'd2, 16'd1}, 32'h0, mkctl(3'd2, 1'b0, 2'b01, 1'b0, 1'b0), 100, 0, 0);

    // R2 stop by loading type 000 while stalled; R7 stall holds address
    do_load(32'h40, {16'd100, 16'd1}, 32'h0, mkctl(3'd2, 1'b0, 2'b01, 1'b1, 1'b0));
    for (int k = 0; k < 3; k++) begin
      chk("R7 stalled valid", {31'b0, addr_valid}, 32'd1);
      chk("R7 stalled address", addr, 32'h40);
      @(negedge clk);
    end
    do_load(32'h0, 32'h0, 32'h0, 32'h0);
    chk("R2 stop busy", {31'b0, busy}, 32'd0);
    chk("R2 stop valid", {31'b0, addr_valid}, 32'd0);
    chk("R2 stop no error", {31'b0, cfg_err}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      chk("R2 stop no done", {31'b0, done}, 32'd0);
      @(negedge clk);
    end

    // random descriptors
    for (int i = 0; i < 30; i++) begin
      logic [1:0]  ln;
      logic [15:0] xc, yc, xm, ym;
      logic [2:0]  ty;
      logic        d2, ie, pc;
      int          w;
      ln = 2'($urandom_range(1, 3));
      w  = op_words(ln);
      xc = 16'(w * (1 + $urandom % 4));
      if (($urandom % 4 == 0) && w > 1) xc = xc - 16'(w - 1);
      xm = 16'(int'($urandom % 16) - 8);
      yc = 16'(1 + $urandom % 4);
      ym = 16'(int'($urandom % 64) - 32);
      d2 = 1'($urandom);
      ie = 1'($urandom);
      pc = 1'($urandom);
      ty = 3'($urandom_range(1, 7));
      run_xfer($urandom, {xc, xm}, {yc, ym},
               {ty, 1'($urandom), d2, ln, ie, pc, 23'($urandom)},
               40 + int'($urandom % 61), 30 + int'($urandom % 71), int'($urandom % 3));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule